// File: doc/BRIEF.md
# Serial Port Interrupt Request Controller

This block turns the status events of a FIFO-buffered serial port into requests for the rest of the chip. Two FIFO level conditions come straight from the transmitter and receiver. Four one-cycle event pulses (receive data-ready timeout, receive error, break, overrun) are caught in sticky flags that software clears by writing 0 to the flag's bit. From these, and from three enable bits, the block drives four separate interrupt lines to an interrupt controller: transmit, receive, receive-error and break. It also drives a DMA request line for transmit and one for receive, and a code that names the highest-priority interrupt line now asserted.

Transmit and receive requests can be steered to DMA with a per-direction select input. When steered, the DMA line rises and the matching CPU line stays low. The data-ready flag adds to the receive request only in asynchronous mode. A separate error enable lets the error and break lines fire while the receive line stays quiet. Every request output is registered.

Top module: `sio_irq_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, all enables, sticky flags, interrupt lines and DMA lines are 0 and `pend_code` is 0.
- R2: With the transmit enable (cfg bit 0) set and `tx_lvl` high, a transmit request is raised. It goes to `irq_tx` when `dma_sel_tx` is 0 and to `dreq_tx` when it is 1. It falls when either condition goes away.
- R3: With the receive enable (cfg bit 1) set, a receive request is raised when `rx_lvl` is high or the data-ready flag (flag bit 0) is set. It goes to `irq_rx`, or to `dreq_rx` when `dma_sel_rx` is 1.
- R4: When `mode_sync` is 1, the data-ready flag has no effect on the receive request. Only `rx_lvl` can raise it.
- R5: `irq_err` follows the receive-error flag (bit 1). `irq_brk` follows the OR of the break flag (bit 2) and the overrun flag (bit 3). Both are enabled when cfg bit 1 or cfg bit 2 is set, and both stay low when neither is set.
- R6: With only the error enable (cfg bit 2) set, `irq_err` and `irq_brk` still assert while `irq_rx` and `dreq_rx` stay low.
- R7: A transmit or receive request steered to DMA never asserts its CPU line, and the two lines of a direction are never high together. Error and break requests always use their CPU lines.
- R8: Each sticky flag is set by a one-cycle pulse on its event input. It is cleared only by a write with `flag_we` high and a 0 in its bit of `flag_wdata`. A 1 in that bit leaves it unchanged. Flags are visible on `flags_o`.
- R9: When an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R10: `pend_code` reports the highest-priority asserted CPU line, in the order break (4), error (3), receive (2), transmit (1), and 0 when no line is asserted.
- R11: A request output changes on the clock edge after the edge that changes the flag or enable that causes it. For a level input, it changes on the first edge that sees the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_lvl | input | 1 | Transmit FIFO at or below its threshold |
| rx_lvl | input | 1 | Receive FIFO at or above its threshold |
| rx_tmo_evt | input | 1 | Pulse: receive data-ready timeout |
| rx_err_evt | input | 1 | Pulse: framing or parity error |
| brk_evt | input | 1 | Pulse: break detected |
| ovr_evt | input | 1 | Pulse: receive overrun |
| mode_sync | input | 1 | 1 = clocked synchronous, 0 = asynchronous |
| dma_sel_tx | input | 1 | Steer the transmit request to DMA |
| dma_sel_rx | input | 1 | Steer the receive request to DMA |
| cfg_we | input | 1 | Write strobe for the enable bits |
| cfg_wdata | input | 3 | Enables: bit0 transmit, bit1 receive, bit2 error |
| flag_we | input | 1 | Write strobe for flag clearing |
| flag_wdata | input | 4 | 0 clears: bit0 data-ready, bit1 error, bit2 break, bit3 overrun |
| flags_o | output | 4 | Sticky flags, same bit order |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rx | output | 1 | Receive interrupt line |
| irq_err | output | 1 | Receive-error interrupt line |
| irq_brk | output | 1 | Break/overrun interrupt line |
| dreq_tx | output | 1 | Transmit DMA request |
| dreq_rx | output | 1 | Receive DMA request |
| pend_code | output | 3 | Highest-priority asserted interrupt line |

## Verification
The embedded properties check on every cycle that the CPU and DMA lines of a direction are never high together, and that a flag stays set until a clearing write. They also check that a pulse always leaves its flag set, that synchronous mode without a full receive FIFO never yields a receive request, that error and break stay masked with both enables off, and that the priority code names an asserted line. The timing of each request, the switch from synchronous to asynchronous mode while a data-ready flag is still set, and the same-cycle contest between a set and a clear can only be shown by the bench's scenarios. The bench compares these against its cycle model.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
   // request slots, low index = low priority
   localparam int SRC_TX  = 0;
   localparam int SRC_RX  = 1;
   localparam int SRC_ERR = 2;
   localparam int SRC_BRK = 3;
   localparam int NSRC    = 4;

   // sticky flag bit positions (visible to software)
   localparam int FLG_DRDY = 0;
   localparam int FLG_RERR = 1;
   localparam int FLG_BRK  = 2;
   localparam int FLG_OVR  = 3;
   localparam int NFLAG    = 4;

   // enable bit positions
   localparam int EN_TX  = 0;
   localparam int EN_RX  = 1;
   localparam int EN_ERR = 2;
   localparam int NEN    = 3;

   typedef enum logic [2:0] {
      PEND_NONE = 3'd0,
      PEND_TX   = 3'd1,
      PEND_RX   = 3'd2,
      PEND_ERR  = 3'd3,
      PEND_BRK  = 3'd4
   } pend_e;
endpackage

// File: rtl/sio_irq_flags.sv
module sio_irq_flags #(
   parameter int NF = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set_evt,
   input  logic          clr_we,
   input  logic [NF-1:0] clr_data,
   output logic [NF-1:0] flg_q
);
   if (NF < 1) begin : g_bad_nf
      $error("sio_irq_flags: NF must be at least 1");
   end

   for (genvar i = 0; i < NF; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flg_q[i] <= 1'b0;
         else if (set_evt[i])
            flg_q[i] <= 1'b1;          // set beats clear
         else if (clr_we && !clr_data[i])
            flg_q[i] <= 1'b0;
      end

      // R8
      flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flg_q[i] && !(clr_we && !clr_data[i])) |=> flg_q[i]);
      // R9
      flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_evt[i] |=> flg_q[i]);
   end
endmodule

// File: rtl/sio_irq_req.sv
module sio_irq_req
   import sio_irq_pkg::*;
#(
   parameter bit HAS_DMA = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NEN-1:0]   en,
   input  logic [NFLAG-1:0] flg,
   input  logic             tx_lvl,
   input  logic             rx_lvl,
   input  logic             mode_sync,
   input  logic             dma_sel_tx,
   input  logic             dma_sel_rx,
   output logic [NSRC-1:0]  irq_q,
   output logic             dreq_tx_q,
   output logic             dreq_rx_q
);
   logic tx_cond, rx_cond, drdy_ok, err_gate;
   logic steer_tx, steer_rx;
   logic [NSRC-1:0] irq_d;

   assign drdy_ok  = flg[FLG_DRDY] && !mode_sync;
   assign tx_cond  = en[EN_TX] && tx_lvl;
   assign rx_cond  = en[EN_RX] && (rx_lvl || drdy_ok);
   assign err_gate = en[EN_RX] || en[EN_ERR];

   if (HAS_DMA) begin : g_dma
      assign steer_tx = dma_sel_tx;
      assign steer_rx = dma_sel_rx;
   end else begin : g_nodma
      logic unused_sel;
      assign unused_sel = dma_sel_tx ^ dma_sel_rx;
      assign steer_tx = 1'b0;
      assign steer_rx = 1'b0;
   end

   always_comb begin
      irq_d          = '0;
      irq_d[SRC_TX]  = tx_cond && !steer_tx;
      irq_d[SRC_RX]  = rx_cond && !steer_rx;
      irq_d[SRC_ERR] = err_gate && flg[FLG_RERR];
      irq_d[SRC_BRK] = err_gate && (flg[FLG_BRK] || flg[FLG_OVR]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q     <= '0;
         dreq_tx_q <= 1'b0;
         dreq_rx_q <= 1'b0;
      end else begin
         irq_q     <= irq_d;
         dreq_tx_q <= tx_cond && steer_tx;
         dreq_rx_q <= rx_cond && steer_rx;
      end
   end

   // R7
   tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_q[SRC_TX] && dreq_tx_q));
   // R7
   rx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_q[SRC_RX] && dreq_rx_q));
   // R4
   sync_drdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sync && !rx_lvl) |=> !(irq_q[SRC_RX] || dreq_rx_q));
   // R5
   err_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[EN_RX] && !en[EN_ERR]) |=> !(irq_q[SRC_ERR] || irq_q[SRC_BRK]));
endmodule

// File: rtl/sio_irq_prio.sv
module sio_irq_prio #(
   parameter int NS = 4,
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NS-1:0] req,
   output logic [CW-1:0] code
);
   if (CW < $clog2(NS + 1)) begin : g_bad_cw
      $error("sio_irq_prio: CW too narrow for NS sources");
   end

   always_comb begin
      code = '0;
      for (int i = 0; i < NS; i++)
         if (req[i]) code = CW'(i + 1);
   end

   // R10
   prio_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code != '0) |-> req[int'(code) - 1]);
   // R10
   prio_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req[NS-1] |-> (code == CW'(NS)));
   // R10
   prio_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |-> (code == '0));
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
   import sio_irq_pkg::*;
#(
   parameter bit HAS_DMA = 1'b1,
   parameter int CODE_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_lvl,
   input  logic             rx_lvl,
   input  logic             rx_tmo_evt,
   input  logic             rx_err_evt,
   input  logic             brk_evt,
   input  logic             ovr_evt,
   input  logic             mode_sync,
   input  logic             dma_sel_tx,
   input  logic             dma_sel_rx,
   input  logic             cfg_we,
   input  logic [NEN-1:0]   cfg_wdata,
   input  logic             flag_we,
   input  logic [NFLAG-1:0] flag_wdata,
   output logic [NFLAG-1:0] flags_o,
   output logic             irq_tx,
   output logic             irq_rx,
   output logic             irq_err,
   output logic             irq_brk,
   output logic             dreq_tx,
   output logic             dreq_rx,
   output logic [CODE_W-1:0] pend_code
);
   localparam int MIN_CW = $clog2(NSRC + 1);

   if (CODE_W < MIN_CW) begin : g_bad_code
      $error("sio_irq_ctrl: CODE_W below %0d", MIN_CW);
   end

   logic [NEN-1:0]   en_q;
   logic [NFLAG-1:0] evt_vec;
   logic [NFLAG-1:0] flg_q;
   logic [NSRC-1:0]  irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= '0;
      else if (cfg_we) en_q <= cfg_wdata;
   end

   always_comb begin
      evt_vec           = '0;
      evt_vec[FLG_DRDY] = rx_tmo_evt;
      evt_vec[FLG_RERR] = rx_err_evt;
      evt_vec[FLG_BRK]  = brk_evt;
      evt_vec[FLG_OVR]  = ovr_evt;
   end

   sio_irq_flags #(.NF(NFLAG)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_evt  (evt_vec),
      .clr_we   (flag_we),
      .clr_data (flag_wdata),
      .flg_q    (flg_q)
   );

   sio_irq_req #(.HAS_DMA(HAS_DMA)) u_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en_q),
      .flg        (flg_q),
      .tx_lvl     (tx_lvl),
      .rx_lvl     (rx_lvl),
      .mode_sync  (mode_sync),
      .dma_sel_tx (dma_sel_tx),
      .dma_sel_rx (dma_sel_rx),
      .irq_q      (irq_q),
      .dreq_tx_q  (dreq_tx),
      .dreq_rx_q  (dreq_rx)
   );

   sio_irq_prio #(.NS(NSRC), .CW(CODE_W)) u_prio (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (irq_q),
      .code  (pend_code)
   );

   assign flags_o = flg_q;
   assign irq_tx  = irq_q[SRC_TX];
   assign irq_rx  = irq_q[SRC_RX];
   assign irq_err = irq_q[SRC_ERR];
   assign irq_brk = irq_q[SRC_BRK];

   // R1
   rst_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (irq_q == '0 && !dreq_tx && !dreq_rx));
endmodule

// File: tb/sio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module sio_irq_ctrl_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_lvl = 0, rx_lvl = 0, rx_tmo_evt = 0, rx_err_evt = 0, brk_evt = 0, ovr_evt = 0;
   logic mode_sync = 0, dma_sel_tx = 0, dma_sel_rx = 0;
   logic cfg_we = 0, flag_we = 0;
   logic [2:0] cfg_wdata = '0;
   logic [3:0] flag_wdata = '1;
   logic [3:0] flags_o;
   logic irq_tx, irq_rx, irq_err, irq_brk, dreq_tx, dreq_rx;
   logic [2:0] pend_code;

   int n_chk = 0, n_fail = 0;
   bit cmp_on = 0, done = 0;

   always #2.5 clk = ~clk;

   sio_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
      .rx_tmo_evt(rx_tmo_evt), .rx_err_evt(rx_err_evt), .brk_evt(brk_evt), .ovr_evt(ovr_evt),
      .mode_sync(mode_sync), .dma_sel_tx(dma_sel_tx), .dma_sel_rx(dma_sel_rx),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .flag_we(flag_we), .flag_wdata(flag_wdata),
      .flags_o(flags_o), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err), .irq_brk(irq_brk),
      .dreq_tx(dreq_tx), .dreq_rx(dreq_rx), .pend_code(pend_code));

   // behavioural reference state
   int m_en[3];
   int m_flg[4];
   int m_itx, m_irx, m_ierr, m_ibrk, m_dtx, m_drx, m_pend;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_en[i]) m_en[i] = 0;
         foreach (m_flg[i]) m_flg[i] = 0;
         m_itx = 0; m_irx = 0; m_ierr = 0; m_ibrk = 0; m_dtx = 0; m_drx = 0; m_pend = 0;
      end else begin
         int want_tx, want_rx, gate;
         int evts[4];
         want_tx = (m_en[0] != 0 && tx_lvl) ? 1 : 0;
         want_rx = (m_en[1] != 0 && (rx_lvl || (m_flg[0] != 0 && !mode_sync))) ? 1 : 0;
         gate    = (m_en[1] != 0 || m_en[2] != 0) ? 1 : 0;
         m_itx  = (want_tx && !dma_sel_tx) ? 1 : 0;
         m_dtx  = (want_tx && dma_sel_tx) ? 1 : 0;
         m_irx  = (want_rx && !dma_sel_rx) ? 1 : 0;
         m_drx  = (want_rx && dma_sel_rx) ? 1 : 0;
         m_ierr = (gate && m_flg[1] != 0) ? 1 : 0;
         m_ibrk = (gate && (m_flg[2] != 0 || m_flg[3] != 0)) ? 1 : 0;
         if (m_ibrk != 0) m_pend = 4;
         else if (m_ierr != 0) m_pend = 3;
         else if (m_irx != 0) m_pend = 2;
         else if (m_itx != 0) m_pend = 1;
         else m_pend = 0;
         evts[0] = rx_tmo_evt; evts[1] = rx_err_evt; evts[2] = brk_evt; evts[3] = ovr_evt;
         for (int i = 0; i < 4; i++) begin
            if (evts[i] != 0) m_flg[i] = 1;
            else if (flag_we && !flag_wdata[i]) m_flg[i] = 0;
         end
         if (cfg_we) for (int i = 0; i < 3; i++) m_en[i] = cfg_wdata[i];
      end
   end

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) if (cmp_on) begin
      chk("R2 irq_tx", irq_tx, m_itx);
      chk("R3 irq_rx", irq_rx, m_irx);
      chk("R5 irq_err", irq_err, m_ierr);
      chk("R5 irq_brk", irq_brk, m_ibrk);
      chk("R7 dreq_tx", dreq_tx, m_dtx);
      chk("R7 dreq_rx", dreq_rx, m_drx);
      chk("R10 pend_code", pend_code, m_pend);
      chk("R8 flags_o", flags_o, m_flg[0] + 2*m_flg[1] + 4*m_flg[2] + 8*m_flg[3]);
   end

   task automatic nxt(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_en(logic [2:0] v);
      cfg_we = 1; cfg_wdata = v; nxt(1); cfg_we = 0;
   endtask

   task automatic clr(logic [3:0] v);
      flag_we = 1; flag_wdata = v; nxt(1); flag_we = 0; flag_wdata = '1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      nxt(3);
      // R1 reset state
      chk("R1 irq lines", {irq_tx, irq_rx, irq_err, irq_brk}, 0);
      chk("R1 dma lines", {dreq_tx, dreq_rx}, 0);
      chk("R1 flags", flags_o, 0);
      chk("R1 pend", pend_code, 0);
      rst_n = 1; cmp_on = 1;
      nxt(1);
      chk("R1 after release", {irq_tx, irq_rx, irq_err, irq_brk, dreq_tx, dreq_rx}, 0);

      // R11 latency: enable write then request one edge later
      tx_lvl = 1;
      set_en(3'b001);
      chk("R11 tx not yet", irq_tx, 0);
      nxt(1);
      chk("R11 tx one clock after enable", irq_tx, 1);
      chk("R10 pend tx", pend_code, 1);
      tx_lvl = 0; nxt(1);
      chk("R2 tx drops with level", irq_tx, 0);

      // R7 transmit steered to DMA
      dma_sel_tx = 1; tx_lvl = 1; nxt(1);
      chk("R7 dreq_tx", dreq_tx, 1);
      chk("R7 irq_tx quiet", irq_tx, 0);
      tx_lvl = 0; dma_sel_tx = 0; nxt(1);

      // R3 receive via FIFO level, then via DMA
      set_en(3'b011);
      rx_lvl = 1; nxt(1);
      chk("R3 rx from level", irq_rx, 1);
      dma_sel_rx = 1; nxt(1);
      chk("R7 dreq_rx", dreq_rx, 1);
      chk("R7 irq_rx quiet", irq_rx, 0);
      dma_sel_rx = 0; rx_lvl = 0; nxt(1);
      chk("R3 rx idle", irq_rx, 0);

      // R3 data-ready in async mode
      rx_tmo_evt = 1; nxt(1); rx_tmo_evt = 0;
      chk("R8 drdy flag set", flags_o[0], 1);
      nxt(1);
      chk("R3 rx from data-ready", irq_rx, 1);
      clr(4'b1111);
      chk("R8 write of 1 keeps flag", flags_o[0], 1);
      clr(4'b1110);
      chk("R8 write of 0 clears flag", flags_o[0], 0);
      nxt(1);
      chk("R3 rx drops after clear", irq_rx, 0);

      // R4 synchronous mode ignores data-ready
      mode_sync = 1;
      rx_tmo_evt = 1; nxt(1); rx_tmo_evt = 0;
      nxt(2);
      chk("R4 drdy ignored in sync", irq_rx, 0);
      rx_lvl = 1; nxt(1);
      chk("R4 level still works in sync", irq_rx, 1);
      rx_lvl = 0; mode_sync = 0; nxt(1);
      chk("R4 async again with flag set", irq_rx, 1);
      clr(4'b1110); nxt(1);

      // R6 error enable alone
      set_en(3'b100);
      rx_lvl = 1;
      rx_err_evt = 1; nxt(1); rx_err_evt = 0;
      nxt(1);
      chk("R6 err raised", irq_err, 1);
      chk("R6 rx stays low", irq_rx, 0);
      chk("R10 pend err", pend_code, 3);
      brk_evt = 1; nxt(1); brk_evt = 0; nxt(1);
      chk("R5 brk from break", irq_brk, 1);
      chk("R10 pend brk over err", pend_code, 4);
      clr(4'b1011); nxt(1);
      chk("R5 brk cleared", irq_brk, 0);
      chk("R10 pend back to err", pend_code, 3);
      ovr_evt = 1; nxt(1); ovr_evt = 0; nxt(1);
      chk("R5 brk from overrun", irq_brk, 1);

      // R5 masked with both enables off
      set_en(3'b000); nxt(1);
      chk("R5 err masked", irq_err, 0);
      chk("R5 brk masked", irq_brk, 0);
      chk("R5 flags kept while masked", flags_o, 4'b1010);
      rx_lvl = 0;

      // R9 set wins over clear in the same cycle
      flag_we = 1; flag_wdata = 4'b0000; rx_err_evt = 1; nxt(1);
      flag_we = 0; flag_wdata = '1; rx_err_evt = 0;
      chk("R9 set wins", flags_o, 4'b0010);
      clr(4'b0000);
      chk("R8 all cleared", flags_o, 0);

      // mixed pattern: all enables, several sources
      set_en(3'b111);
      tx_lvl = 1; rx_lvl = 1; ovr_evt = 1; nxt(1); ovr_evt = 0;
      nxt(1);
      chk("R10 brk highest", pend_code, 4);
      clr(4'b0111); nxt(1);
      chk("R10 rx above tx", pend_code, 2);
      rx_lvl = 0; nxt(1);
      chk("R10 tx lowest", pend_code, 1);
      tx_lvl = 0; nxt(2);
      chk("R10 none", pend_code, 0);

      cmp_on = 0;
      finish_run();
   end
endmodule